// File: doc/BRIEF.md
# In-band Xon/Xoff flow-control detector

This block watches the receive character stream of one serial channel for programmed flow-control characters. When the far end sends the "stop" character (or two-character stop sequence), the local transmitter is told to pause. When it sends the "go" character (or sequence), the transmitter is allowed to resume. Characters consumed as flow control are removed from the stream. All other characters pass through to the receive path unchanged and in order.

The receive stream enters and leaves on valid/ready handshakes. A character moves on a port when valid and ready are both high at a rising clock edge. The transmitter is paused through a level, `tx_suspend`. That level only changes on a cycle where the transmitter reports a character boundary, so a character already on the line is never cut short. A stop detection also raises an interrupt request, which stays high until a status read clears it.

Four character registers and a 4-bit mode field are plain inputs and are held steady by the host. Only bits 1:0 of the mode field are decoded here: 00 means off, 01 means single character set 1, 10 means single character set 2, and 11 means a two-character pair.

Top module: `sw_flow_ctl`

## Requirements
- R1: After reset, `tx_suspend`, `irq` and `out_valid` are 0.
- R2: Matching is chosen by `mode[1:0]`: 00 off, 01 single using `xon1_chr`/`xoff1_chr`, 10 single using `xon2_chr`/`xoff2_chr`, 11 pair. Bits 3:2 of `mode` have no effect on this block.
- R3: In mode 01, a received `xoff1_chr` is consumed without output and requests suspension. A received `xon1_chr` is consumed without output and withdraws the request. If a character equals both values, stop wins.
- R4: In mode 10, the same behaviour applies with `xoff2_chr`/`xon2_chr`. In this mode, characters equal to the set-1 values pass through.
- R5: In mode 11, `xoff1_chr` immediately followed by `xoff2_chr` is consumed as a pair and requests suspension. `xon1_chr` immediately followed by `xon2_chr` is consumed and withdraws the request. Neither character appears at the output.
- R6: In mode 11, when a held first character is followed by a character that does not complete its pair, the held character is emitted first. The new character is then handled as a fresh character, in order.
- R7: `tx_suspend` follows the suspension request only on a clock edge where `tx_boundary` is 1. The request updates on the edge that accepts the deciding character.
- R8: While `mode[1:0]` is 00, every character passes through. `tx_suspend` and the request are forced to 0 on the next edge.
- R9: `irq` goes to 1 on the edge that accepts a completed stop detection. It stays 1 until an edge with `irq_clr` high and no new stop detection.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. A flow-control character that is consumed is accepted whatever the state of `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | Flow-control select; bits 1:0 decoded |
| xon1_chr | input | W | Go character 1 |
| xon2_chr | input | W | Go character 2 |
| xoff1_chr | input | W | Stop character 1 |
| xoff2_chr | input | W | Stop character 2 |
| in_valid | input | 1 | Received character valid |
| in_ready | output | 1 | Received character accepted |
| in_data | input | W | Received character |
| out_valid | output | 1 | Forwarded character valid |
| out_ready | input | 1 | Receive path can take a character |
| out_data | output | W | Forwarded character |
| tx_boundary | input | 1 | Transmitter is between characters |
| tx_suspend | output | 1 | Pause the transmitter |
| irq_clr | input | 1 | Status read, clears `irq` |
| irq | output | 1 | Stop detected interrupt request |

## Verification
A wrong pair-detector state shows up on the very next received character. Either a held character is lost or duplicated in the output stream, or a pair is missed and both characters leak through. The scoreboard catches these on the next handshake. A wrong request register shows up at `tx_suspend` on the first boundary cycle after the deciding character, and at `irq` one edge after acceptance. The bench therefore samples these a fixed number of edges after each character. It also checks that `tx_suspend` does not move while `tx_boundary` is low.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_OFF  = 2'b00,
    FC_SET1 = 2'b01,
    FC_SET2 = 2'b10,
    FC_PAIR = 2'b11
  } fc_mode_e;

  // index of each programmed character in the compare array
  localparam int IDX_ON1  = 0;
  localparam int IDX_ON2  = 1;
  localparam int IDX_OFF1 = 2;
  localparam int IDX_OFF2 = 3;
  localparam int NREF     = 4;
endpackage

// File: rtl/fc_match.sv
module fc_match
  import fc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]            chr,
  input  logic [NREF-1:0][W-1:0]  ref_chr,
  output logic [NREF-1:0]         eq
);
  for (genvar g = 0; g < NREF; g++) begin : g_cmp
    assign eq[g] = (chr == ref_chr[g]);
  end
endmodule

// File: rtl/fc_seq.sv
module fc_seq
  import fc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  fc_mode_e        sel,
  input  logic [W-1:0]    xon2_chr,
  input  logic [W-1:0]    xoff2_chr,
  input  logic [NREF-1:0] eq,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_data,
  output logic            evt_on,
  output logic            evt_off
);
  logic         held_vld, held_off;
  logic [W-1:0] held_chr;
  logic         load_held, drop_held;
  logic         hit_on, hit_off, pair_done;

  always_comb begin
    hit_on  = 1'b0;
    hit_off = 1'b0;
    unique case (sel)
      FC_SET1: begin hit_off = eq[IDX_OFF1]; hit_on = eq[IDX_ON1]; end
      FC_SET2: begin hit_off = eq[IDX_OFF2]; hit_on = eq[IDX_ON2]; end
      FC_PAIR: begin hit_off = eq[IDX_OFF1]; hit_on = eq[IDX_ON1]; end
      default: ;
    endcase
    pair_done = held_off ? (in_data == xoff2_chr) : (in_data == xon2_chr);
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = in_data;
    in_ready  = 1'b0;
    evt_on    = 1'b0;
    evt_off   = 1'b0;
    load_held = 1'b0;
    drop_held = 1'b0;
    if (held_vld && (sel != FC_PAIR)) begin
      // mode left pair matching: flush the held character
      out_valid = 1'b1;
      out_data  = held_chr;
      drop_held = out_ready;
    end else if (held_vld) begin
      if (in_valid) begin
        if (pair_done) begin
          in_ready  = 1'b1;
          drop_held = 1'b1;
          evt_off   = held_off;
          evt_on    = !held_off;
        end else begin
          out_valid = 1'b1;
          out_data  = held_chr;
          drop_held = out_ready;
        end
      end
    end else if (in_valid && (hit_off || hit_on)) begin
      in_ready = 1'b1;
      if (sel == FC_PAIR) begin
        load_held = 1'b1;
      end else begin
        evt_off = hit_off;
        evt_on  = !hit_off;
      end
    end else begin
      out_valid = in_valid;
      in_ready  = out_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld <= 1'b0;
      held_off <= 1'b0;
      held_chr <= '0;
    end else if (load_held) begin
      held_vld <= 1'b1;
      held_off <= hit_off;
      held_chr <= in_data;
    end else if (drop_held) begin
      held_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/fc_gate.sv
module fc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic evt_on,
  input  logic evt_off,
  input  logic tx_boundary,
  input  logic irq_clr,
  output logic tx_suspend,
  output logic irq
);
  logic stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_req   <= 1'b0;
      tx_suspend <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (!enable)      stop_req <= 1'b0;
      else if (evt_off) stop_req <= 1'b1;
      else if (evt_on)  stop_req <= 1'b0;

      if (!enable)          tx_suspend <= 1'b0;
      else if (tx_boundary) tx_suspend <= stop_req;

      if (evt_off)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/sw_flow_ctl.sv
module sw_flow_ctl
  import fc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode,
  input  logic [W-1:0] xon1_chr,
  input  logic [W-1:0] xon2_chr,
  input  logic [W-1:0] xoff1_chr,
  input  logic [W-1:0] xoff2_chr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  input  logic         tx_boundary,
  output logic         tx_suspend,
  input  logic         irq_clr,
  output logic         irq
);
  fc_mode_e              sel;
  logic [NREF-1:0][W-1:0] refs;
  logic [NREF-1:0]       eq;
  logic                  evt_on, evt_off;
  logic                  unused_hi;

  assign sel            = fc_mode_e'(mode[1:0]);
  assign unused_hi      = ^mode[3:2];
  assign refs[IDX_ON1]  = xon1_chr;
  assign refs[IDX_ON2]  = xon2_chr;
  assign refs[IDX_OFF1] = xoff1_chr;
  assign refs[IDX_OFF2] = xoff2_chr;

  fc_match #(.W(W)) u_match (
    .chr(in_data), .ref_chr(refs), .eq(eq)
  );

  fc_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .xon2_chr(xon2_chr), .xoff2_chr(xoff2_chr), .eq(eq),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .evt_on(evt_on), .evt_off(evt_off)
  );

  fc_gate u_gate (
    .clk(clk), .rst_n(rst_n), .enable(sel != FC_OFF),
    .evt_on(evt_on), .evt_off(evt_off), .tx_boundary(tx_boundary),
    .irq_clr(irq_clr), .tx_suspend(tx_suspend), .irq(irq)
  );
endmodule

// File: rtl/fc_chk.sv
module fc_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   mode,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic         tx_boundary,
  input logic         tx_suspend,
  input logic         irq_clr,
  input logic         irq
);
  // R7
  suspend_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_suspend) |-> $past(tx_boundary));
  // R8
  off_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'b00) |=> !tx_suspend);
  // R9
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(in_valid && in_ready));
  // R10
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind sw_flow_ctl fc_chk #(.W(W)) u_fc_chk (.*);

// File: tb/test_sw_flow_ctl.sv
module test_sw_flow_ctl;
  localparam int W = 8;
  localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h91, OFF1 = 8'h13, OFF2 = 8'h93;

  logic clk = 0, rst_n = 0;
  logic [3:0] mode = 4'h0;
  logic in_valid = 0, out_ready = 1, tx_boundary = 0, irq_clr = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, tx_suspend, irq;
  logic [W-1:0] out_data;
  int checks = 0, errors = 0;
  logic [W-1:0] expq[$];

  always #2 clk = ~clk;

  sw_flow_ctl #(.W(W)) i_sw_flow_ctl (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .xon1_chr(ON1), .xon2_chr(ON2), .xoff1_chr(OFF1), .xoff2_chr(OFF2),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tx_boundary(tx_boundary), .tx_suspend(tx_suspend),
    .irq_clr(irq_clr), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected forwarded characters at each output handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) check("R6 unexpected output", {24'h0, out_data}, 32'hFFFF);
      else check("R3/R5/R6 stream order", {24'h0, out_data}, {24'h0, expq.pop_front()});
    end
  end

  // driver; caller sits 1 ns after a rising edge
  task automatic send(input logic [W-1:0] b, input bit fwd);
    if (fwd) expq.push_back(b);
    in_valid = 1; in_data = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    check("R1 tx_suspend", tx_suspend, 0);
    check("R1 irq", irq, 0);
    check("R1 out_valid", out_valid, 0);
    rst_n = 1; step(1);

    // R8: off mode forwards flow-control characters
    send(OFF1, 1); send(8'h41, 1); step(1);
    check("R8 no suspend when off", tx_suspend, 0);
    check("R8 no irq when off", irq, 0);

    // R3 single set 1, with upper bits set (R2)
    mode = 4'b1101;
    send(8'h42, 1); send(OFF1, 0);
    check("R9 irq on stop", irq, 1);
    check("R7 held without boundary", tx_suspend, 0);
    step(2);
    check("R7 still held", tx_suspend, 0);
    tx_boundary = 1; step(1);
    check("R3 suspended at boundary", tx_suspend, 1);
    send(ON1, 0); step(1);
    check("R3 resumed", tx_suspend, 0);
    check("R9 irq sticky", irq, 1);
    irq_clr = 1; step(1); irq_clr = 0;
    check("R9 irq cleared", irq, 0);

    // R4 set 2, set-1 chars pass
    mode = 4'b0010;
    send(OFF1, 1); step(1);
    check("R4 set1 char ignored", tx_suspend, 0);
    send(OFF2, 0); step(1);
    check("R4 set2 stop", tx_suspend, 1);
    check("R2 mode bits 3:2", irq, 1);
    // R8 disable releases suspension
    mode = 4'b0000; step(1);
    check("R8 released", tx_suspend, 0);
    irq_clr = 1; step(1); irq_clr = 0;

    // R5 pair
    mode = 4'b0011;
    send(OFF1, 0); send(OFF2, 0); step(1);
    check("R5 pair stop", tx_suspend, 1);
    send(ON1, 0); step(1);
    check("R5 half pair no resume", tx_suspend, 1);
    send(ON2, 0); step(1);
    check("R5 pair resume", tx_suspend, 0);
    // R6 broken pair: held char then new char
    send(OFF1, 1); send(8'h55, 1); step(1);
    check("R6 no suspend on broken pair", tx_suspend, 0);
    send(ON1, 1); send(OFF1, 0); send(OFF2, 0); step(1);
    check("R6 restart after break", tx_suspend, 1);
    send(ON1, 0); send(ON2, 0); step(1);

    // R10 back-pressure
    mode = 4'b0001; tx_boundary = 0;
    out_ready = 0; in_valid = 1; in_data = 8'h60;
    step(3);
    check("R10 stalled", in_ready, 0);
    expq.push_back(8'h60);
    out_ready = 1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1; in_valid = 0;
    out_ready = 0; in_valid = 1; in_data = OFF1;
    #1; check("R10 stop accepted under back-pressure", in_ready, 1);
    step(1); in_valid = 0; out_ready = 1;
    check("R9 irq from back-pressured stop", irq, 1);
    step(3);
    check("R7 no boundary no change", tx_suspend, 0);
    check("R6 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule